// File: doc/BRIEF.md
# Write-Only Two-Wire Register Sequencer

This block generates the clock and data line activity needed to set single registers in a clock synthesizer over a two-wire I2C-style bus. A transfer is a start condition, the fixed device address byte, the register number, one data byte and a stop condition. Every byte goes out most significant bit first. Each byte is followed by a ninth clock pulse with the data line held low. That pulse is never sampled, so the bus is written blind. Both lines are open-drain: the block outputs pull-down enables. A low enable releases the line, which then floats high.

After reset the block waits an idle delay with both lines released. It then plays a fixed four-write setup script into the synthesizer. After that it accepts requests from a single client. The client offers a register number and a data byte with a one-cycle request while `busy_o` is low. `busy_o` stays high from the cycle after acceptance until the stop condition has finished. A programmable divider sets the pacing. Every line state lasts one phase of three timing units, and one unit is `div_i + 1` clock cycles.

Top module: `i2c_regwr_seq`

## Requirements
- R1: While `busy_o` is low, both `scl_oe_o` and `sda_oe_o` are 0, so both lines are released.
- R2: From reset `busy_o` is high. The first start condition comes no sooner than `STARTUP_UNITS*(div_i+1)` cycles after reset release. Four writes then follow in this order: register 183 data 0x92, register 16 data 0x80, register 177 data 0xA0, register 16 data 0x4E. `busy_o` falls only after the fourth stop.
- R3: A frame is framed by two conditions. It opens with SDA falling while SCL is released, and it closes with SDA released while SCL is released. Between them are three bytes, each sent MSB first and sampled at SCL rising: 0xC0, then the register, then the data.
- R4: After the eight bits of every byte comes a ninth SCL pulse, and SDA is pulled low during it. The line is not read back.
- R5: Every SCL high pulse inside a byte lasts exactly `3*(div_i+1)` clock cycles. No SCL high period is shorter than that.
- R6: In any single clock cycle, at most one of the two line enables changes.
- R7: A request is taken in a cycle where `req_i` is high and `busy_o` is low, and `busy_o` is high in the next cycle. `busy_o` never rises except after such a request.
- R8: A request made while `busy_o` is high is ignored. It produces no frame, and it does not keep `busy_o` high after the running frame ends.
- R9: `busy_o` falls in the cycle after the stop condition's final phase ends, with both lines already released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | DIV_W | Timing unit length minus one, in clock cycles; hold stable during a frame |
| req_i | input | 1 | One-cycle write request, taken while busy_o is low |
| reg_i | input | 8 | Register number for the request |
| data_i | input | 8 | Data byte for the request |
| busy_o | output | 1 | High during startup, the setup script and any frame |
| scl_oe_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong phase or bit-counter state appears on the lines within one phase. It shows as an SCL pulse of the wrong length, as both lines moving in the same cycle, or as a frame of the wrong bit count that the bench decoder rejects at the stop condition. A corrupted shift register shows as a wrong decoded byte, visible by the end of that byte. A wrong sequencer state shows as a missing or extra frame, a misordered setup script, or `busy_o` being high or low for a whole frame time when it should not be.

// File: rtl/i2c_seq_pkg.sv
// Shared types and the fixed setup script for the register write sequencer.
// Assumes the script is short and constant; entries are computed by function.
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        ENG_IDLE,
        ENG_ST_A,   // both released
        ENG_ST_B,   // data low, clock released: start condition
        ENG_ST_C,   // both low
        ENG_B_SET,  // clock low, data carries bit
        ENG_B_HI,   // clock released, data carries bit
        ENG_B_LO,   // clock low, data carries bit
        ENG_SP_A,   // both low
        ENG_SP_B,   // clock released, data low
        ENG_SP_C    // both released: stop condition
    } eng_state_t;

    typedef enum logic [1:0] {
        SEQ_BOOT,
        SEQ_LAUNCH,
        SEQ_WAIT,
        SEQ_READY
    } seq_state_t;

    localparam int INIT_LEN = 4;
    localparam int INIT_IW  = $clog2(INIT_LEN);

    // Register number of setup write idx.
    function automatic logic [7:0] init_reg(input logic [INIT_IW-1:0] idx);
        case (idx)
            2'd0:    return 8'd183;
            2'd1:    return 8'd16;
            2'd2:    return 8'd177;
            default: return 8'd16;
        endcase
    endfunction

    // Data byte of setup write idx.
    function automatic logic [7:0] init_val(input logic [INIT_IW-1:0] idx);
        case (idx)
            2'd0:    return 8'h92;
            2'd1:    return 8'h80;
            2'd2:    return 8'hA0;
            default: return 8'h4E;
        endcase
    endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
// Phase timer: counts units of (div_i+1) cycles and flags the last cycle of
// a phase of PHASE_UNITS units. Assumes div_i is stable while run_i is high.
// Counters clear whenever run_i is low, so a phase starts fresh on run.
module i2c_phase_timer #(
    parameter int DIV_W       = 8,
    parameter int PHASE_UNITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             phase_end_o
);
    localparam int UW = (PHASE_UNITS > 1) ? $clog2(PHASE_UNITS) : 1;
    localparam logic [UW-1:0] LAST_UNIT = UW'(PHASE_UNITS - 1);

    logic [DIV_W-1:0] cyc_q;
    logic [UW-1:0]    unit_q;
    logic             unit_tick;

    assign unit_tick   = run_i && (cyc_q == div_i);
    assign phase_end_o = unit_tick && (unit_q == LAST_UNIT);

    // Cycle and unit counters, wrapping at the end of each unit and phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cyc_q  <= '0;
            unit_q <= '0;
        end else if (unit_tick) begin
            cyc_q  <= '0;
            unit_q <= phase_end_o ? '0 : unit_q + 1'b1;
        end else begin
            cyc_q  <= cyc_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_byte_engine.sv
// Frame engine: on start_i (only honoured when idle) sends start, address,
// register, data and stop, with a ninth low-data clock after each byte.
// Each line state lasts one timer phase; one line changes per transition.
module i2c_byte_engine
    import i2c_seq_pkg::*;
#(
    parameter int         DIV_W    = 8,
    parameter logic [7:0] DEV_ADDR = 8'hC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             start_i,
    input  logic [7:0]       reg_i,
    input  logic [7:0]       data_i,
    output logic             done_o,
    output logic             scl_oe_o,
    output logic             sda_oe_o
);
    localparam int BYTES      = 3;
    localparam int SLOT       = 9;
    localparam int FRAME_BITS = BYTES * SLOT;
    localparam int CW         = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

    eng_state_t            st_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [CW-1:0]         cnt_q;
    logic                  phase_end;
    logic                  bit_low;

    i2c_phase_timer #(.DIV_W(DIV_W), .PHASE_UNITS(3)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (st_q != ENG_IDLE),
        .div_i       (div_i),
        .phase_end_o (phase_end)
    );

    assign done_o  = (st_q == ENG_SP_C) && phase_end;
    assign bit_low = ~sh_q[FRAME_BITS-1];

    // Phase sequencing, frame load and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ENG_IDLE;
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (st_q == ENG_IDLE) begin
            if (start_i) begin
                sh_q  <= {DEV_ADDR, 1'b0, reg_i, 1'b0, data_i, 1'b0};
                cnt_q <= '0;
                st_q  <= ENG_ST_A;
            end
        end else if (phase_end) begin
            case (st_q)
                ENG_ST_A:  st_q <= ENG_ST_B;
                ENG_ST_B:  st_q <= ENG_ST_C;
                ENG_ST_C:  st_q <= ENG_B_SET;
                ENG_B_SET: st_q <= ENG_B_HI;
                ENG_B_HI:  st_q <= ENG_B_LO;
                ENG_B_LO: begin
                    if (cnt_q == LAST_BIT) begin
                        st_q <= ENG_SP_A;
                    end else begin
                        sh_q  <= sh_q << 1;
                        cnt_q <= cnt_q + 1'b1;
                        st_q  <= ENG_B_SET;
                    end
                end
                ENG_SP_A:  st_q <= ENG_SP_B;
                ENG_SP_B:  st_q <= ENG_SP_C;
                default:   st_q <= ENG_IDLE;
            endcase
        end
    end

    // Line enables per phase: 1 pulls low, 0 releases.
    always_comb begin
        case (st_q)
            ENG_ST_B:  begin scl_oe_o = 1'b0; sda_oe_o = 1'b1;    end
            ENG_ST_C:  begin scl_oe_o = 1'b1; sda_oe_o = 1'b1;    end
            ENG_B_SET: begin scl_oe_o = 1'b1; sda_oe_o = bit_low; end
            ENG_B_HI:  begin scl_oe_o = 1'b0; sda_oe_o = bit_low; end
            ENG_B_LO:  begin scl_oe_o = 1'b1; sda_oe_o = bit_low; end
            ENG_SP_A:  begin scl_oe_o = 1'b1; sda_oe_o = 1'b1;    end
            ENG_SP_B:  begin scl_oe_o = 1'b0; sda_oe_o = 1'b1;    end
            default:   begin scl_oe_o = 1'b0; sda_oe_o = 1'b0;    end
        endcase
    end
endmodule

// File: rtl/i2c_regwr_seq.sv
// Register write sequencer top: startup delay, fixed setup script, then
// client writes through a req/busy handshake. Assumes one client that only
// requests while busy_o is low; requests during busy are dropped.
module i2c_regwr_seq
    import i2c_seq_pkg::*;
#(
    parameter int         DIV_W         = 8,
    parameter int         STARTUP_UNITS = 200,
    parameter logic [7:0] DEV_ADDR      = 8'hC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             req_i,
    input  logic [7:0]       reg_i,
    input  logic [7:0]       data_i,
    output logic             busy_o,
    output logic             scl_oe_o,
    output logic             sda_oe_o
);
    localparam logic [INIT_IW-1:0] LAST_INIT = INIT_IW'(INIT_LEN - 1);

    seq_state_t         st_q;
    logic [INIT_IW-1:0] idx_q;
    logic               init_mode_q;
    logic               boot_done;
    logic               eng_start;
    logic               eng_done;
    logic [7:0]         eng_reg;
    logic [7:0]         eng_data;

    i2c_phase_timer #(.DIV_W(DIV_W), .PHASE_UNITS(STARTUP_UNITS)) u_boot_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (st_q == SEQ_BOOT),
        .div_i       (div_i),
        .phase_end_o (boot_done)
    );

    i2c_byte_engine #(.DIV_W(DIV_W), .DEV_ADDR(DEV_ADDR)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_i    (div_i),
        .start_i  (eng_start),
        .reg_i    (eng_reg),
        .data_i   (eng_data),
        .done_o   (eng_done),
        .scl_oe_o (scl_oe_o),
        .sda_oe_o (sda_oe_o)
    );

    assign busy_o    = (st_q != SEQ_READY);
    assign eng_start = (st_q == SEQ_LAUNCH) || ((st_q == SEQ_READY) && req_i);
    assign eng_reg   = (st_q == SEQ_LAUNCH) ? init_reg(idx_q) : reg_i;
    assign eng_data  = (st_q == SEQ_LAUNCH) ? init_val(idx_q) : data_i;

    // Sequencer: boot delay, script stepping, client acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= SEQ_BOOT;
            idx_q       <= '0;
            init_mode_q <= 1'b1;
        end else begin
            case (st_q)
                SEQ_BOOT:   if (boot_done) st_q <= SEQ_LAUNCH;
                SEQ_LAUNCH: st_q <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (eng_done) begin
                        if (init_mode_q && (idx_q != LAST_INIT)) begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= SEQ_LAUNCH;
                        end else begin
                            init_mode_q <= 1'b0;
                            st_q        <= SEQ_READY;
                        end
                    end
                end
                default:    if (req_i) st_q <= SEQ_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/i2c_regwr_seq_chk.sv
// Protocol checker for the register write sequencer, bound to the top.
// Observes ports only; assumes div_i is stable while a frame runs.
module i2c_regwr_seq_chk #(
    parameter int DIV_W       = 8,
    parameter int PHASE_UNITS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_i,
    input logic             req_i,
    input logic             busy_o,
    input logic             scl_oe_o,
    input logic             sda_oe_o
);
    logic [15:0] hi_cnt_q;
    int          need;

    assign need = PHASE_UNITS * (int'(div_i) + 1);

    // Length of the current released-clock run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || scl_oe_o) hi_cnt_q <= '0;
        else if (hi_cnt_q != 16'hFFFF) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));

    assert_scl_high_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe_o) |-> (int'(hi_cnt_q) >= need));

    assert_single_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(scl_oe_o) || $stable(sda_oe_o));

    assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_i));
endmodule

bind i2c_regwr_seq i2c_regwr_seq_chk #(.DIV_W(DIV_W), .PHASE_UNITS(3)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_i    (div_i),
    .req_i    (req_i),
    .busy_o   (busy_o),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
);

// File: tb/test_i2c_regwr_seq.sv
// Directed bench: a line decoder rebuilds frames from the enables, and one
// task per scenario checks the decoded frames and handshake.
module test_i2c_regwr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int STARTUP    = 20;
    localparam int LIMIT      = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div = 8'd1;
    logic       req = 1'b0;
    logic [7:0] reg_b = 8'd0;
    logic [7:0] dat_b = 8'd0;
    logic       busy, scl_oe, sda_oe;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit ended = 0;

    i2c_regwr_seq #(.DIV_W(8), .STARTUP_UNITS(STARTUP)) i_i2c_regwr_seq (
        .clk (clk), .rst_n (rst_n), .div_i (div), .req_i (req),
        .reg_i (reg_b), .data_i (dat_b), .busy_o (busy),
        .scl_oe_o (scl_oe), .sda_oe_o (sda_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- line decoder ----------------
    logic [7:0] log_a [0:31];
    logic [7:0] log_r [0:31];
    logic [7:0] log_d [0:31];
    int  n_log = 0;
    int  n_pulse = 0;
    bit  p_scl = 1, p_sda = 1, in_frame = 0, pulse_bit = 0;
    int  bitn = 0, rise_at = 0;
    logic [7:0] acc [0:2];

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        bit scl, sda;
        scl = !scl_oe;
        sda = !sda_oe;
        if (rst_n) begin
            if (scl != p_scl && sda != p_sda)
                check(0, "R6 both lines moved", 2, 1);
            if (p_scl && scl && p_sda && !sda) begin
                in_frame = 1; bitn = 0;
            end else if (p_scl && scl && !p_sda && sda && in_frame) begin
                check(bitn == 27, "R3 frame bit count", bitn, 27);
                if (n_log < 32) begin
                    log_a[n_log] = acc[0]; log_r[n_log] = acc[1]; log_d[n_log] = acc[2];
                end
                n_log++;
                in_frame = 0;
            end
            if (!p_scl && scl) begin
                rise_at = cyc;
                pulse_bit = in_frame && bitn < 27;
                if (pulse_bit) begin
                    if (bitn % 9 == 8) check(sda_oe == 1'b1, "R4 ninth clock data low", sda_oe, 1);
                    else acc[bitn/9] = {acc[bitn/9][6:0], sda};
                    bitn++;
                end
            end
            if (p_scl && !scl && pulse_bit) begin
                n_pulse++;
                check(cyc - rise_at == 3*(div+1), "R5 clock high width", cyc - rise_at, 3*(div+1));
                pulse_bit = 0;
            end
        end
        p_scl = scl;
        p_sda = sda;
    end

    // ---------------- helpers ----------------
    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] r, input logic [7:0] d);
        wait_idle();
        reg_b = r; dat_b = d; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R7 busy one cycle after request", busy, 1);
        wait_idle();
    endtask

    task automatic expect_frame(input int k, input logic [7:0] r, input logic [7:0] d, input string tag);
        check(log_a[k] == 8'hC0, {tag, " address byte"}, log_a[k], 8'hC0);
        check(log_r[k] == r, {tag, " register byte"}, log_r[k], r);
        check(log_d[k] == d, {tag, " data byte"}, log_d[k], d);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_boot();
        int t;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(!scl_oe && !sda_oe, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
        rst_n = 1'b1;
        t = 0;
        while (!sda_oe && t < 5000) begin
            @(negedge clk); t++;
            if (t == 1) check(busy == 1'b1, "R2 busy from reset", busy, 1);
        end
        check(t >= STARTUP*(div+1) && t <= STARTUP*(div+1) + 3*(div+1) + 4,
              "R2 startup delay", t, STARTUP*(div+1));
    endtask

    task automatic t_init();
        wait_idle();
        check(n_log == 4, "R2 setup write count", n_log, 4);
        expect_frame(0, 8'd183, 8'h92, "R2 setup 0");
        expect_frame(1, 8'd16,  8'h80, "R2 setup 1");
        expect_frame(2, 8'd177, 8'hA0, "R2 setup 2");
        expect_frame(3, 8'd16,  8'h4E, "R2 setup 3");
        check(!scl_oe && !sda_oe, "R9 lines released when idle", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_write(input logic [7:0] r, input logic [7:0] d);
        int k, p0;
        k = n_log; p0 = n_pulse;
        do_write(r, d);
        check(n_log == k + 1, "R3 one frame per request", n_log, k + 1);
        expect_frame(k, r, d, "R3 client write");
        check(n_pulse - p0 == 27, "R4 R5 pulses per frame", n_pulse - p0, 27);
    endtask

    task automatic t_busy_timing();
        int t;
        wait_idle();
        reg_b = 8'h21; dat_b = 8'h43; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        t = 0;
        while (busy && t < 20000) begin
            @(negedge clk); t++;
            if (busy && t > 2) check(1'b1, "R9 busy during frame", 1, 1);
            if (busy) ;
        end
        // frame: 87 phases; busy lasts until the cycle after the last phase
        check(t == 87*3*(div+1), "R9 busy length", t, 87*3*(div+1));
        check(!scl_oe && !sda_oe, "R9 lines released at busy fall", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_ignore();
        int k;
        wait_idle();
        k = n_log;
        reg_b = 8'h1A; dat_b = 8'h5C; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (50) @(negedge clk);
        reg_b = 8'h33; dat_b = 8'h44; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wait_idle();
        repeat (300) @(negedge clk);
        check(busy == 1'b0, "R8 no busy from dropped request", busy, 0);
        check(n_log == k + 1, "R8 dropped request made no frame", n_log, k + 1);
        expect_frame(k, 8'h1A, 8'h5C, "R8 running frame intact");
    endtask

    task automatic t_divider();
        div = 8'd3;
        t_write(8'h77, 8'hA5);
        div = 8'd1;
    endtask

    initial begin
        t_boot();
        t_init();
        t_write(8'h1A, 8'h5C);
        t_write(8'hFF, 8'h00);
        t_write(8'h01, 8'h80);
        t_busy_timing();
        t_ignore();
        t_divider();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(negedge clk) begin
        if (cyc >= LIMIT && !ended) begin
            ended = 1;
            check(0, "watchdog expired", cyc, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule